// File: doc/BRIEF.md
# Streamed Pairwise Correlation Checker

This block checks two-object correlation conditions inside a single bunch crossing. At the crossing-start marker it captures a whole collection of up to `N_HELD` reference objects in parallel and keeps them unchanged for the whole crossing. Objects of the second collection arrive one per fast-clock cycle over `SLOTS` consecutive cycles, where `SLOTS` is 12 by default because the fast clock runs at twelve times the crossing rate. Each streamed object is paired with every held object in the same cycle, so `N_HELD` pair units, reused over the `SLOTS` cycles, form every pair in the crossing.

For each pair the block computes the absolute pseudorapidity distance, the azimuthal distance folded over the phi period, the squared angular distance, the scalar sum of transverse momenta and a charge relation. Each of these is compared against configuration inputs. The pass results of all pairs in all slots are ORed into one decision, and a one-cycle strobe presents that decision a fixed number of cycles after the last slot.

The sequencer is a two-state machine. `S_IDLE` waits for `bx_start`. The transition *crossing accepted* (`S_IDLE` to `S_STREAM`, taken when `bx_start` is high) captures the held collection and consumes slot 0. `S_STREAM` consumes slots 1 to `SLOTS-1`, one per cycle. The transition *last slot consumed* (`S_STREAM` to `S_IDLE`) is taken in the cycle that consumes slot `SLOTS-1`. A new crossing may start in the very next cycle. Configuration inputs must stay stable from the crossing start until the decision strobe.

Top module: `corr_pair_checker`

## Requirements
- R1: The held collection is captured only on the cycle where `bx_start` is sampled in `S_IDLE`. Changes on the held inputs during the stream have no effect on the decision. A `bx_start` that arrives while in `S_STREAM` is ignored and does not restart the crossing.
- R2: The streamed object on the `str_*` inputs is consumed as slot k in the k-th cycle after the accepted `bx_start` (slot 0 in that same cycle), for k = 0 to `SLOTS-1`. Objects in slot 0 and in slot `SLOTS-1` both take part.
- R3: The eta distance is |η_s − η_h|, where each eta is a two's-complement signed value of `ETA_W` bits.
- R4: The phi distance d = |φ_s − φ_h| is replaced by `PHI_PERIOD − d` when d > `PHI_PERIOD/2`. Phi values are unsigned and lie in 0 to `PHI_PERIOD−1`.
- R5: A pair passes the angular check only when `cfg_dr2_lo` ≤ Δη² + Δφ² ≤ `cfg_dr2_hi`, with both bounds inclusive.
- R6: A pair passes the momentum check only when pt_s + pt_h ≥ `cfg_sumpt_min`.
- R7: `cfg_chg_mode` selects the charge check. 0 means any charge. 1 requires opposite sign (charge bits differ). 2 requires same sign (charge bits equal). 3 behaves like 0. A charge bit of 1 means negative.
- R8: When `cfg_same_coll` is 1, the pair formed by held index i and stream slot k with i == k never passes. When it is 0, that pair is treated like any other.
- R9: A pair whose held object or streamed object is invalid never passes.
- R10: `dec_valid` is high for exactly one cycle, beginning at the clock edge `SLOTS+2` cycles after the edge that samples the accepted `bx_start`. `dec_pass` is the OR of all pair results of that crossing, and is 0 whenever `dec_valid` is 0.
- R11: While reset is asserted, `dec_valid` and `dec_pass` are 0 and the sequencer is in `S_IDLE`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock (SLOTS times the crossing rate) |
| rst_n | input | 1 | Asynchronous active-low reset |
| bx_start | input | 1 | Crossing-start marker; slot 0 is on the stream inputs in this cycle |
| held_valid | input | N_HELD | Valid bit per held object |
| held_pt | input | N_HELD*PT_W | Transverse momentum per held object, object i at bits [i*PT_W +: PT_W] |
| held_eta | input | N_HELD*ETA_W | Signed eta per held object |
| held_phi | input | N_HELD*PHI_W | Unsigned phi per held object |
| held_q | input | N_HELD | Charge bit per held object (1 = negative) |
| str_valid | input | 1 | Valid bit of the streamed object |
| str_pt | input | PT_W | Transverse momentum of the streamed object |
| str_eta | input | ETA_W | Signed eta of the streamed object |
| str_phi | input | PHI_W | Unsigned phi of the streamed object |
| str_q | input | 1 | Charge bit of the streamed object |
| cfg_dr2_lo | input | DR2_W | Inclusive lower bound on squared angular distance |
| cfg_dr2_hi | input | DR2_W | Inclusive upper bound on squared angular distance |
| cfg_sumpt_min | input | PT_W+1 | Minimum scalar pt sum |
| cfg_chg_mode | input | 2 | Charge requirement selector |
| cfg_same_coll | input | 1 | Both collections are the same: exclude self pairs |
| dec_valid | output | 1 | One-cycle decision strobe |
| dec_pass | output | 1 | Crossing decision, qualified by dec_valid |

## Verification
The bench targets these corner cases:

- An eta pair that straddles zero. Here a design that dropped the sign extension would report a huge distance.
- A phi pair across the wrap point. An unfolded design sees a distance of 138 rather than 6 and misses the window.
- Squared distances and pt sums sitting exactly on their bounds. An off-by-one comparison flips these results.
- All four charge codes, and self pairs with the same-collection flag on and off. Swapping the charge codes or comparing the wrong index shows up as a wrong decision.
- Passing pairs placed only in slot 0 or only in slot `SLOTS-1`.
- A second `bx_start` and scrambled held inputs in the middle of a stream. A sequencer that restarts or re-captures would lose the crossing or borrow pairs from garbage.
- Back-to-back random crossings. These catch an accumulator that leaks results from one crossing into the next, and a strobe that arrives in the wrong cycle.

// File: rtl/corr_pkg.sv
package corr_pkg;

    // Charge requirement codes carried on cfg_chg_mode
    typedef enum logic [1:0] {
        CHG_ANY     = 2'd0,
        CHG_OPP     = 2'd1,
        CHG_SAME    = 2'd2,
        CHG_ANY_ALT = 2'd3
    } chg_mode_e;

    // Slot sequencer states
    typedef enum logic {
        S_IDLE   = 1'b0,
        S_STREAM = 1'b1
    } seq_state_e;

endpackage

// File: rtl/corr_seq.sv
module corr_seq
    import corr_pkg::*;
#(
    parameter int N_HELD = 6,
    parameter int SLOTS  = 12,
    parameter int SLOT_W = 4,
    parameter int PT_W   = 10,
    parameter int ETA_W  = 9,
    parameter int PHI_W  = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      bx_start,
    input  logic [N_HELD-1:0]         held_valid,
    input  logic [N_HELD*PT_W-1:0]    held_pt,
    input  logic [N_HELD*ETA_W-1:0]   held_eta,
    input  logic [N_HELD*PHI_W-1:0]   held_phi,
    input  logic [N_HELD-1:0]         held_q,
    input  logic                      str_valid,
    input  logic [PT_W-1:0]           str_pt,
    input  logic [ETA_W-1:0]          str_eta,
    input  logic [PHI_W-1:0]          str_phi,
    input  logic                      str_q,
    output seq_state_e                state_o,
    output logic [SLOT_W-1:0]         slot_o,
    output logic [N_HELD-1:0]         held_valid_q,
    output logic [N_HELD*PT_W-1:0]    held_pt_q,
    output logic [N_HELD*ETA_W-1:0]   held_eta_q,
    output logic [N_HELD*PHI_W-1:0]   held_phi_q,
    output logic [N_HELD-1:0]         held_q_q,
    output logic                      a_vld,
    output logic                      a_first,
    output logic                      a_last,
    output logic [SLOT_W-1:0]         a_slot,
    output logic                      a_sv,
    output logic [PT_W-1:0]           a_pt,
    output logic [ETA_W-1:0]          a_eta,
    output logic [PHI_W-1:0]          a_phi,
    output logic                      a_q
);

    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS - 1);

    seq_state_e        state_q, state_d;
    logic [SLOT_W-1:0] slot_q, slot_d;
    logic              consume_c, first_c, last_c, capture_c;
    logic [SLOT_W-1:0] slot_c;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            slot_q  <= '0;
        end else begin
            state_q <= state_d;
            slot_q  <= slot_d;
        end
    end

    // Next state and per-cycle outputs
    always_comb begin
        state_d   = state_q;
        slot_d    = slot_q;
        consume_c = 1'b0;
        first_c   = 1'b0;
        last_c    = 1'b0;
        capture_c = 1'b0;
        slot_c    = slot_q;
        unique case (state_q)
            S_IDLE: begin
                if (bx_start) begin
                    capture_c = 1'b1;
                    consume_c = 1'b1;
                    first_c   = 1'b1;
                    slot_c    = '0;
                    if (SLOTS == 1) begin
                        last_c = 1'b1;
                    end else begin
                        state_d = S_STREAM;
                        slot_d  = SLOT_W'(1);
                    end
                end
            end
            S_STREAM: begin
                consume_c = 1'b1;
                if (slot_q == LAST_SLOT) begin
                    last_c  = 1'b1;
                    state_d = S_IDLE;
                    slot_d  = '0;
                end else begin
                    slot_d = slot_q + SLOT_W'(1);
                end
            end
        endcase
    end

    // Held collection capture and stage A of the stream
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held_valid_q <= '0;
            held_pt_q    <= '0;
            held_eta_q   <= '0;
            held_phi_q   <= '0;
            held_q_q     <= '0;
            a_vld        <= 1'b0;
            a_first      <= 1'b0;
            a_last       <= 1'b0;
            a_slot       <= '0;
            a_sv         <= 1'b0;
            a_pt         <= '0;
            a_eta        <= '0;
            a_phi        <= '0;
            a_q          <= 1'b0;
        end else begin
            if (capture_c) begin
                held_valid_q <= held_valid;
                held_pt_q    <= held_pt;
                held_eta_q   <= held_eta;
                held_phi_q   <= held_phi;
                held_q_q     <= held_q;
            end
            a_vld   <= consume_c;
            a_first <= consume_c & first_c;
            a_last  <= consume_c & last_c;
            a_slot  <= slot_c;
            a_sv    <= consume_c & str_valid;
            a_pt    <= str_pt;
            a_eta   <= str_eta;
            a_phi   <= str_phi;
            a_q     <= str_q;
        end
    end

    assign state_o = state_q;
    assign slot_o  = slot_q;

endmodule

// File: rtl/corr_pair_unit.sv
module corr_pair_unit
    import corr_pkg::*;
#(
    parameter int IDX        = 0,
    parameter int SLOT_W     = 4,
    parameter int PT_W       = 10,
    parameter int ETA_W      = 9,
    parameter int PHI_W      = 8,
    parameter int PHI_PERIOD = 144,
    parameter int DR2_W      = 19
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_vld,
    input  logic [SLOT_W-1:0] a_slot,
    input  logic              a_sv,
    input  logic [PT_W-1:0]   a_pt,
    input  logic [ETA_W-1:0]  a_eta,
    input  logic [PHI_W-1:0]  a_phi,
    input  logic              a_q,
    input  logic              h_valid,
    input  logic [PT_W-1:0]   h_pt,
    input  logic [ETA_W-1:0]  h_eta,
    input  logic [PHI_W-1:0]  h_phi,
    input  logic              h_q,
    input  logic              cfg_same_coll,
    input  logic [PT_W:0]     cfg_sumpt_min,
    input  logic [1:0]        cfg_chg_mode,
    input  logic [DR2_W-1:0]  cfg_dr2_lo,
    input  logic [DR2_W-1:0]  cfg_dr2_hi,
    output logic              pair_pass
);

    localparam int HALF_PERIOD = PHI_PERIOD / 2;

    logic signed [ETA_W:0] eta_diff;
    logic [ETA_W-1:0]      deta_c;
    logic [PHI_W-1:0]      dphi_raw, dphi_c;
    logic [PT_W:0]         sum_c;
    logic                  self_c, chg_c, ok_c;

    logic                  b_ok;
    logic [ETA_W-1:0]      b_deta;
    logic [PHI_W-1:0]      b_dphi;
    logic [DR2_W-1:0]      dr2_c;
    logic                  c_ok;
    logic [DR2_W-1:0]      c_dr2;

    // Stage B: distances, momentum sum, charge and validity
    always_comb begin
        eta_diff = $signed({a_eta[ETA_W-1], a_eta}) - $signed({h_eta[ETA_W-1], h_eta});
        deta_c   = eta_diff[ETA_W] ? ETA_W'(-eta_diff) : eta_diff[ETA_W-1:0];
        dphi_raw = (a_phi >= h_phi) ? (a_phi - h_phi) : (h_phi - a_phi);
        dphi_c   = (int'(dphi_raw) > HALF_PERIOD) ? PHI_W'(PHI_PERIOD - int'(dphi_raw)) : dphi_raw;
        sum_c    = {1'b0, a_pt} + {1'b0, h_pt};
        self_c   = cfg_same_coll && (int'(a_slot) == IDX);
        case (cfg_chg_mode)
            CHG_OPP:  chg_c = (a_q != h_q);
            CHG_SAME: chg_c = (a_q == h_q);
            default:  chg_c = 1'b1;
        endcase
        ok_c = a_vld & a_sv & h_valid & ~self_c & (sum_c >= cfg_sumpt_min) & chg_c;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            b_ok   <= 1'b0;
            b_deta <= '0;
            b_dphi <= '0;
        end else begin
            b_ok   <= ok_c;
            b_deta <= deta_c;
            b_dphi <= dphi_c;
        end
    end

    // Stage C: squared angular distance
    always_comb begin
        dr2_c = DR2_W'(b_deta) * DR2_W'(b_deta) + DR2_W'(b_dphi) * DR2_W'(b_dphi);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_ok  <= 1'b0;
            c_dr2 <= '0;
        end else begin
            c_ok  <= b_ok;
            c_dr2 <= dr2_c;
        end
    end

    assign pair_pass = c_ok && (c_dr2 >= cfg_dr2_lo) && (c_dr2 <= cfg_dr2_hi);

endmodule

// File: rtl/corr_merge.sv
module corr_merge #(
    parameter int N_HELD = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              c_vld,
    input  logic              c_first,
    input  logic              c_last,
    input  logic [N_HELD-1:0] pass_vec,
    output logic              dec_valid,
    output logic              dec_pass
);

    logic any_c, merged_c, acc_q;

    always_comb begin
        any_c    = |pass_vec;
        merged_c = c_first ? any_c : (acc_q | any_c);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q     <= 1'b0;
            dec_valid <= 1'b0;
            dec_pass  <= 1'b0;
        end else begin
            if (c_vld) begin
                acc_q <= merged_c;
            end
            dec_valid <= c_vld & c_last;
            dec_pass  <= c_vld & c_last & merged_c;
        end
    end

endmodule

// File: rtl/corr_pair_checker.sv
module corr_pair_checker
    import corr_pkg::*;
#(
    parameter int N_HELD     = 6,
    parameter int SLOTS      = 12,
    parameter int PT_W       = 10,
    parameter int ETA_W      = 9,
    parameter int PHI_W      = 8,
    parameter int PHI_PERIOD = 144,
    parameter int DR2_W      = 2 * ((ETA_W > PHI_W) ? ETA_W : PHI_W) + 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bx_start,
    input  logic [N_HELD-1:0]        held_valid,
    input  logic [N_HELD*PT_W-1:0]   held_pt,
    input  logic [N_HELD*ETA_W-1:0]  held_eta,
    input  logic [N_HELD*PHI_W-1:0]  held_phi,
    input  logic [N_HELD-1:0]        held_q,
    input  logic                     str_valid,
    input  logic [PT_W-1:0]          str_pt,
    input  logic [ETA_W-1:0]         str_eta,
    input  logic [PHI_W-1:0]         str_phi,
    input  logic                     str_q,
    input  logic [DR2_W-1:0]         cfg_dr2_lo,
    input  logic [DR2_W-1:0]         cfg_dr2_hi,
    input  logic [PT_W:0]            cfg_sumpt_min,
    input  logic [1:0]               cfg_chg_mode,
    input  logic                     cfg_same_coll,
    output logic                     dec_valid,
    output logic                     dec_pass
);

    localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;
    localparam int HB_W   = N_HELD * (2 + PT_W + ETA_W + PHI_W);

    seq_state_e                seq_state;
    logic [SLOT_W-1:0]         seq_slot;
    logic [N_HELD-1:0]         held_valid_q;
    logic [N_HELD*PT_W-1:0]    held_pt_q;
    logic [N_HELD*ETA_W-1:0]   held_eta_q;
    logic [N_HELD*PHI_W-1:0]   held_phi_q;
    logic [N_HELD-1:0]         held_q_q;
    logic                      a_vld, a_first, a_last, a_sv, a_q;
    logic [SLOT_W-1:0]         a_slot;
    logic [PT_W-1:0]           a_pt;
    logic [ETA_W-1:0]          a_eta;
    logic [PHI_W-1:0]          a_phi;
    logic                      b_vld, b_first, b_last;
    logic                      c_vld, c_first, c_last;
    logic [N_HELD-1:0]         pass_vec;
    logic [HB_W-1:0]           held_bus;

    corr_seq #(
        .N_HELD (N_HELD),
        .SLOTS  (SLOTS),
        .SLOT_W (SLOT_W),
        .PT_W   (PT_W),
        .ETA_W  (ETA_W),
        .PHI_W  (PHI_W)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .bx_start     (bx_start),
        .held_valid   (held_valid),
        .held_pt      (held_pt),
        .held_eta     (held_eta),
        .held_phi     (held_phi),
        .held_q       (held_q),
        .str_valid    (str_valid),
        .str_pt       (str_pt),
        .str_eta      (str_eta),
        .str_phi      (str_phi),
        .str_q        (str_q),
        .state_o      (seq_state),
        .slot_o       (seq_slot),
        .held_valid_q (held_valid_q),
        .held_pt_q    (held_pt_q),
        .held_eta_q   (held_eta_q),
        .held_phi_q   (held_phi_q),
        .held_q_q     (held_q_q),
        .a_vld        (a_vld),
        .a_first      (a_first),
        .a_last       (a_last),
        .a_slot       (a_slot),
        .a_sv         (a_sv),
        .a_pt         (a_pt),
        .a_eta        (a_eta),
        .a_phi        (a_phi),
        .a_q          (a_q)
    );

    // Crossing framing travels alongside the two pair stages
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            b_vld   <= 1'b0;
            b_first <= 1'b0;
            b_last  <= 1'b0;
            c_vld   <= 1'b0;
            c_first <= 1'b0;
            c_last  <= 1'b0;
        end else begin
            b_vld   <= a_vld;
            b_first <= a_first;
            b_last  <= a_last;
            c_vld   <= b_vld;
            c_first <= b_first;
            c_last  <= b_last;
        end
    end

    for (genvar gi = 0; gi < N_HELD; gi++) begin : g_pair
        corr_pair_unit #(
            .IDX        (gi),
            .SLOT_W     (SLOT_W),
            .PT_W       (PT_W),
            .ETA_W      (ETA_W),
            .PHI_W      (PHI_W),
            .PHI_PERIOD (PHI_PERIOD),
            .DR2_W      (DR2_W)
        ) u_pair (
            .clk           (clk),
            .rst_n         (rst_n),
            .a_vld         (a_vld),
            .a_slot        (a_slot),
            .a_sv          (a_sv),
            .a_pt          (a_pt),
            .a_eta         (a_eta),
            .a_phi         (a_phi),
            .a_q           (a_q),
            .h_valid       (held_valid_q[gi]),
            .h_pt          (held_pt_q[gi*PT_W +: PT_W]),
            .h_eta         (held_eta_q[gi*ETA_W +: ETA_W]),
            .h_phi         (held_phi_q[gi*PHI_W +: PHI_W]),
            .h_q           (held_q_q[gi]),
            .cfg_same_coll (cfg_same_coll),
            .cfg_sumpt_min (cfg_sumpt_min),
            .cfg_chg_mode  (cfg_chg_mode),
            .cfg_dr2_lo    (cfg_dr2_lo),
            .cfg_dr2_hi    (cfg_dr2_hi),
            .pair_pass     (pass_vec[gi])
        );
    end

    corr_merge #(
        .N_HELD (N_HELD)
    ) u_merge (
        .clk       (clk),
        .rst_n     (rst_n),
        .c_vld     (c_vld),
        .c_first   (c_first),
        .c_last    (c_last),
        .pass_vec  (pass_vec),
        .dec_valid (dec_valid),
        .dec_pass  (dec_pass)
    );

    assign held_bus = {held_valid_q, held_pt_q, held_eta_q, held_phi_q, held_q_q};

endmodule

// File: rtl/corr_pair_checker_sva.sv
module corr_pair_checker_sva
    import corr_pkg::*;
#(
    parameter int SLOTS  = 12,
    parameter int SLOT_W = 4,
    parameter int HB_W   = 8
) (
    input logic              clk,
    input logic              rst_n,
    input seq_state_e        state_i,
    input logic [SLOT_W-1:0] slot_i,
    input logic [HB_W-1:0]   held_bus,
    input logic              a_last,
    input logic              dec_valid,
    input logic              dec_pass
);

    // R1: the held collection does not move while a crossing streams
    a_r1_held_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (state_i == S_STREAM) |=> $stable(held_bus));

    // R1: a marker inside the stream does not end or restart it
    a_r1_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (state_i == S_STREAM && int'(slot_i) != SLOTS - 1) |=> (state_i == S_STREAM));

    // R2: the slot counter stays inside the crossing
    a_r2_slot_range: assert property (@(posedge clk) disable iff (!rst_n)
        int'(slot_i) < SLOTS);

    // R10: the strobe follows the last slot after the pair pipeline
    a_r10_strobe_latency: assert property (@(posedge clk) disable iff (!rst_n)
        a_last |-> ##3 dec_valid);

    // R10: the strobe lasts one cycle
    a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |=> !dec_valid);

    // R10: no decision without the strobe
    a_r10_pass_qualified: assert property (@(posedge clk) disable iff (!rst_n)
        dec_pass |-> dec_valid);

endmodule

bind corr_pair_checker corr_pair_checker_sva #(
    .SLOTS  (SLOTS),
    .SLOT_W (SLOT_W),
    .HB_W   (HB_W)
) u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .state_i   (seq_state),
    .slot_i    (seq_slot),
    .held_bus  (held_bus),
    .a_last    (a_last),
    .dec_valid (dec_valid),
    .dec_pass  (dec_pass)
);

// File: tb/corr_pair_checker_bench.sv
module corr_pair_checker_bench;

    localparam int N   = 6;
    localparam int SL  = 12;
    localparam int PTW = 10;
    localparam int EW  = 9;
    localparam int PW  = 8;
    localparam int PER = 144;
    localparam int DW  = 19;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bx_start = 1'b0;
    logic [N-1:0]      held_valid = '0;
    logic [N*PTW-1:0]  held_pt = '0;
    logic [N*EW-1:0]   held_eta = '0;
    logic [N*PW-1:0]   held_phi = '0;
    logic [N-1:0]      held_q = '0;
    logic              str_valid = 1'b0;
    logic [PTW-1:0]    str_pt = '0;
    logic [EW-1:0]     str_eta = '0;
    logic [PW-1:0]     str_phi = '0;
    logic              str_q = 1'b0;
    logic [DW-1:0]     cfg_dr2_lo = '0;
    logic [DW-1:0]     cfg_dr2_hi = '0;
    logic [PTW:0]      cfg_sumpt_min = '0;
    logic [1:0]        cfg_chg_mode = '0;
    logic              cfg_same_coll = 1'b0;
    logic              dec_valid, dec_pass;

    corr_pair_checker u_corr_pair_checker (
        .clk(clk), .rst_n(rst_n), .bx_start(bx_start),
        .held_valid(held_valid), .held_pt(held_pt), .held_eta(held_eta),
        .held_phi(held_phi), .held_q(held_q),
        .str_valid(str_valid), .str_pt(str_pt), .str_eta(str_eta),
        .str_phi(str_phi), .str_q(str_q),
        .cfg_dr2_lo(cfg_dr2_lo), .cfg_dr2_hi(cfg_dr2_hi),
        .cfg_sumpt_min(cfg_sumpt_min), .cfg_chg_mode(cfg_chg_mode),
        .cfg_same_coll(cfg_same_coll),
        .dec_valid(dec_valid), .dec_pass(dec_pass)
    );

    always #4 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;

    int hv[N], hpt[N], heta[N], hphi[N], hq[N];
    int sv[SL], spt[SL], seta[SL], sphi[SL], sq[SL];
    int c_lo, c_hi, c_thr, c_mode, c_same;

    int    q_cyc[$];
    bit    q_pass[$];
    string q_tag[$];

    task automatic check(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // Reference comparison on every clock
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (q_cyc.size() > 0 && q_cyc[0] == cyc) begin
                check({q_tag[0], " R10 strobe"}, int'(dec_valid), 1);
                check({q_tag[0], " decision"}, int'(dec_pass), int'(q_pass[0]));
                void'(q_cyc.pop_front());
                void'(q_pass.pop_front());
                void'(q_tag.pop_front());
            end else begin
                check("R10 quiet dec_valid", int'(dec_valid), 0);
                check("R10 quiet dec_pass", int'(dec_pass), 0);
            end
        end
    end

    function automatic bit ref_pair(input int i, input int k);
        int de, dp, dr2;
        if (hv[i] == 0 || sv[k] == 0) return 1'b0;
        if (c_same != 0 && i == k) return 1'b0;
        de = seta[k] - heta[i];
        if (de < 0) de = -de;
        dp = sphi[k] - hphi[i];
        if (dp < 0) dp = -dp;
        if (dp > PER / 2) dp = PER - dp;
        dr2 = de * de + dp * dp;
        if (dr2 < c_lo || dr2 > c_hi) return 1'b0;
        if (spt[k] + hpt[i] < c_thr) return 1'b0;
        if (c_mode == 1 && sq[k] == hq[i]) return 1'b0;
        if (c_mode == 2 && sq[k] != hq[i]) return 1'b0;
        return 1'b1;
    endfunction

    task automatic clear_objs();
        for (int i = 0; i < N; i++) begin
            hv[i] = 0; hpt[i] = 0; heta[i] = 0; hphi[i] = 0; hq[i] = 0;
        end
        for (int k = 0; k < SL; k++) begin
            sv[k] = 0; spt[k] = 0; seta[k] = 0; sphi[k] = 0; sq[k] = 0;
        end
    endtask

    task automatic random_objs();
        for (int i = 0; i < N; i++) begin
            hv[i] = ($urandom % 5 != 0) ? 1 : 0;
            hpt[i] = $urandom % 1024;
            heta[i] = int'($urandom % 512) - 256;
            hphi[i] = $urandom % PER;
            hq[i] = $urandom % 2;
        end
        for (int k = 0; k < SL; k++) begin
            sv[k] = ($urandom % 5 != 0) ? 1 : 0;
            spt[k] = $urandom % 1024;
            seta[k] = int'($urandom % 512) - 256;
            sphi[k] = $urandom % PER;
            sq[k] = $urandom % 2;
        end
    endtask

    task automatic drive_held();
        for (int i = 0; i < N; i++) begin
            held_valid[i] = (hv[i] != 0);
            held_pt[i*PTW +: PTW] = PTW'(hpt[i]);
            held_eta[i*EW +: EW] = EW'(heta[i]);
            held_phi[i*PW +: PW] = PW'(hphi[i]);
            held_q[i] = (hq[i] != 0);
        end
    endtask

    task automatic scramble_held();
        for (int i = 0; i < N; i++) begin
            held_valid[i] = ($urandom % 2 != 0);
            held_pt[i*PTW +: PTW] = PTW'($urandom);
            held_eta[i*EW +: EW] = EW'($urandom);
            held_phi[i*PW +: PW] = PW'($urandom % PER);
            held_q[i] = ($urandom % 2 != 0);
        end
    endtask

    task automatic drive_slot(input int k);
        str_valid = (sv[k] != 0);
        str_pt = PTW'(spt[k]);
        str_eta = EW'(seta[k]);
        str_phi = PW'(sphi[k]);
        str_q = (sq[k] != 0);
    endtask

    // Drain the previous crossing, then change configuration
    task automatic apply_cfg(input int lo, input int hi, input int thr, input int mode, input int same);
        repeat (4) @(negedge clk);
        c_lo = lo; c_hi = hi; c_thr = thr; c_mode = mode; c_same = same;
        cfg_dr2_lo = DW'(lo);
        cfg_dr2_hi = DW'(hi);
        cfg_sumpt_min = (PTW+1)'(thr);
        cfg_chg_mode = 2'(mode);
        cfg_same_coll = (same != 0);
    endtask

    // One crossing; held inputs are scrambled after capture (R1)
    task automatic run_crossing(input string tag, input bit restart_mid);
        bit exp_pass = 1'b0;
        for (int i = 0; i < N; i++)
            for (int k = 0; k < SL; k++)
                exp_pass |= ref_pair(i, k);
        @(negedge clk);
        bx_start = 1'b1;
        drive_held();
        drive_slot(0);
        q_cyc.push_back(cyc + SL + 3);
        q_pass.push_back(exp_pass);
        q_tag.push_back(tag);
        for (int k = 1; k < SL; k++) begin
            @(negedge clk);
            bx_start = restart_mid && (k == 5);
            scramble_held();
            drive_slot(k);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_fail++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        c_lo = 0; c_hi = 0; c_thr = 0; c_mode = 0; c_same = 0;
        clear_objs();
        repeat (3) @(negedge clk);
        check("R11 reset dec_valid", int'(dec_valid), 0);
        check("R11 reset dec_pass", int'(dec_pass), 0);
        rst_n = 1'b1;

        // R3: eta across zero
        apply_cfg(0, 100, 0, 0, 0);
        clear_objs();
        hv[0] = 1; heta[0] = -5; hphi[0] = 10; hpt[0] = 5;
        sv[3] = 1; seta[3] = 4; sphi[3] = 10; spt[3] = 5;
        run_crossing("R3 eta span 9 inside", 1'b0);
        seta[3] = 6;
        run_crossing("R3 eta span 11 outside", 1'b0);

        // R4: phi wrap
        apply_cfg(30, 40, 0, 0, 0);
        clear_objs();
        hv[1] = 1; hphi[1] = 2;
        sv[7] = 1; sphi[7] = 140;
        run_crossing("R4 wrapped phi 6", 1'b0);
        sphi[7] = 100;
        run_crossing("R4 folded phi 46", 1'b0);

        // R5: inclusive window bounds
        apply_cfg(25, 25, 0, 0, 0);
        clear_objs();
        hv[0] = 1;
        sv[0] = 1; seta[0] = 3; sphi[0] = 4;
        run_crossing("R5 dr2 on both bounds", 1'b0);
        apply_cfg(26, 40, 0, 0, 0);
        run_crossing("R5 dr2 below lower", 1'b0);
        apply_cfg(10, 24, 0, 0, 0);
        run_crossing("R5 dr2 above upper", 1'b0);

        // R6: pt sum threshold
        apply_cfg(0, 1000, 150, 0, 0);
        clear_objs();
        hv[0] = 1; hpt[0] = 100;
        sv[2] = 1; spt[2] = 50;
        run_crossing("R6 sum equals threshold", 1'b0);
        apply_cfg(0, 1000, 151, 0, 0);
        run_crossing("R6 sum below threshold", 1'b0);

        // R7: charge codes
        apply_cfg(0, 1000, 0, 1, 0);
        clear_objs();
        hv[4] = 1; hq[4] = 0;
        sv[6] = 1; sq[6] = 0;
        run_crossing("R7 opposite with equal charge", 1'b0);
        sq[6] = 1;
        run_crossing("R7 opposite with differing charge", 1'b0);
        apply_cfg(0, 1000, 0, 2, 0);
        run_crossing("R7 same with differing charge", 1'b0);
        sq[6] = 0;
        run_crossing("R7 same with equal charge", 1'b0);
        apply_cfg(0, 1000, 0, 3, 0);
        sq[6] = 1;
        run_crossing("R7 code 3 ignores charge", 1'b0);

        // R8: self pairs
        apply_cfg(0, 1000, 0, 0, 1);
        clear_objs();
        hv[2] = 1; hpt[2] = 7; heta[2] = 20; hphi[2] = 30;
        sv[2] = 1; spt[2] = 7; seta[2] = 20; sphi[2] = 30;
        run_crossing("R8 self pair excluded", 1'b0);
        apply_cfg(0, 1000, 0, 0, 0);
        run_crossing("R8 self pair kept when flag off", 1'b0);
        apply_cfg(0, 1000, 0, 0, 1);
        clear_objs();
        hv[2] = 1; heta[2] = 20; hphi[2] = 30;
        sv[3] = 1; seta[3] = 20; sphi[3] = 30;
        run_crossing("R8 different index kept", 1'b0);

        // R9: invalid sides
        apply_cfg(0, 400000, 0, 0, 0);
        clear_objs();
        for (int i = 0; i < N; i++) hv[i] = 1;
        run_crossing("R9 stream all invalid", 1'b0);
        clear_objs();
        for (int k = 0; k < SL; k++) sv[k] = 1;
        run_crossing("R9 held all invalid", 1'b0);

        // R2: first and last slot, back to back
        clear_objs();
        hv[5] = 1;
        sv[SL-1] = 1;
        run_crossing("R2 last slot only", 1'b0);
        clear_objs();
        hv[0] = 1;
        sv[0] = 1;
        run_crossing("R2 first slot only", 1'b0);
        clear_objs();
        run_crossing("R2 empty after passing crossing", 1'b0);

        // R1: scrambled held inputs and a marker mid-stream
        clear_objs();
        hv[0] = 1;
        sv[4] = 1;
        run_crossing("R1 marker mid-stream ignored", 1'b1);
        clear_objs();
        for (int k = 0; k < SL; k++) sv[k] = 1;
        run_crossing("R1 held changes after capture ignored", 1'b1);

        // R10: random back-to-back crossings under random configurations
        for (int b = 0; b < 6; b++) begin
            int lo;
            lo = $urandom % 3000;
            apply_cfg(lo, lo + int'($urandom % 40000), $urandom % 1200, $urandom % 4, $urandom % 2);
            for (int x = 0; x < 8; x++) begin
                random_objs();
                run_crossing("R10 random crossing", 1'b0);
            end
        end

        repeat (20) @(negedge clk);
        if (q_cyc.size() != 0) check("R10 pending decisions", q_cyc.size(), 0);
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule